// File: doc/BRIEF.md
# Light-Load Conduction Mode Selector

This block decides, one PWM cycle at a time, whether a synchronous buck converter's low-side switch acts as a full synchronous rectifier (forced continuous conduction) or as an emulated diode that blocks reverse inductor current. A mode-select input can pin the converter in continuous conduction. When that input is low, the block watches the phase-polarity comparator while the low-side gate is on. A run of cycles in which the phase node reads positive means the inductor current has reversed. After enough of those cycles in a row, the block switches to diode emulation.

In diode emulation the block withdraws the low-side gate permit whenever reverse current shows up, and it holds the permit off until the next PWM cycle starts. It also tells the modulator to widen its comparator window by one third, which lowers the switching frequency at light load. One negative phase reading while the low-side gate is on shows forward body-diode current. That single reading arms a return to continuous conduction, and the return takes effect at the next PWM strobe. Entry therefore needs a run of cycles, while exit needs only one event.

All inputs are assumed to be synchronous to `clk`. `pwm_strobe` is a single-cycle pulse that marks the start of each PWM cycle.

Top module: `dem_ctrl_top`

## Requirements
- R1: While `force_ccm` is 1, `dem_mode` is 0 no matter how many qualifying strobes arrive.
- R2: With `force_ccm` low and the block in continuous conduction, a strobe is qualifying when `lg_on`=1 and `phase_pos`=1 in the strobe cycle. `dem_mode` becomes 1 at the clock edge of the ENTRY_COUNT-th consecutive qualifying strobe (default 8), and not before that edge.
- R3: In diode emulation, any clock cycle with `lg_on`=1 and `phase_pos`=0 arms an exit. `dem_mode` returns to 0 at the next strobe edge after the arming cycle, and not in the arming cycle itself. After the exit the run count starts again from zero.
- R4: `win_sel` equals WIN_BASE (default 48) in continuous conduction. It equals WIN_BASE + WIN_BASE/3 (default 64) in diode emulation.
- R5: `lg_permit` is 1 in continuous conduction. In diode emulation it becomes 0 one clock after a cycle with `lg_on`=1 and `phase_pos`=1. It becomes 1 again after the next strobe edge on which that condition is absent.
- R6: A strobe with `lg_on`=0 or `phase_pos`=0 resets the consecutive-strobe count to zero. After such a strobe, a full run of ENTRY_COUNT further qualifying strobes is needed to enter diode emulation.
- R7: `force_ccm`=1 for one clock in diode emulation makes `dem_mode` 0 at the next edge. It also clears the run count and any armed exit.
- R8: After reset, `dem_mode`=0, `lg_permit`=1 and `win_sel`=WIN_BASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| force_ccm | input | 1 | 1 holds forced continuous conduction |
| pwm_strobe | input | 1 | One-cycle pulse at the start of each PWM cycle |
| lg_on | input | 1 | Low-side gate is currently on |
| phase_pos | input | 1 | Phase node reads positive (1) or negative (0) |
| dem_mode | output | 1 | 1 = diode emulation, 0 = continuous conduction |
| lg_permit | output | 1 | Permission for the low-side gate to turn or stay on |
| win_sel | output | WIN_W | Window size code for the modulator |

## Verification
Runs of 0 to ENTRY_COUNT+2 qualifying strobes show exactly where entry happens. Runs broken at every position, by the gate being off or by a negative phase, show that the count restarts rather than accumulates. Exit is tried two ways, with the negative reading on a strobe cycle and with it between strobes, and both confirm the one-cycle delay to the next strobe. Pulses on the mode pin, positive-phase cycles inside diode emulation, and the same positive-phase pattern in continuous conduction separate the forced, blocked and permitted cases of the gate permit and the window code.

// File: rtl/dem_pkg.sv
// Shared types for the conduction mode selector.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dem_pkg;
    typedef enum logic {
        MODE_CCM = 1'b0,
        MODE_DEM = 1'b1
    } dem_mode_e;

    // Window code enlarged by one third (integer arithmetic).
    function automatic int unsigned win_enlarged(input int unsigned base);
        return base + base / 3;
    endfunction
endpackage

// File: rtl/dem_entry_counter.sv
// Counts consecutive qualifying PWM strobes in continuous conduction.
// Assumes: strobe is a one-cycle pulse; clear holds the count at zero.
module dem_entry_counter #(
    parameter int ENTRY_COUNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic strobe,
    input  logic qualify,
    output logic hit
);
    localparam int CW = $clog2(ENTRY_COUNT + 1);
    localparam logic [CW-1:0] LAST = CW'(ENTRY_COUNT - 1);

    logic [CW-1:0] run_cnt;

    // Terminal strobe of a complete run.
    assign hit = !clear && strobe && qualify && (run_cnt == LAST);

    // Run length register: advance on qualifying strobes, restart otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clear) begin
            run_cnt <= '0;
        end else if (strobe) begin
            if (!qualify || hit) begin
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dem_mode_fsm.sv
// Holds the conduction mode and the armed-exit flag.
// Assumes: entry_hit comes from the run counter; neg_seen marks a cycle
// with the low-side gate on and a negative phase reading.
module dem_mode_fsm
    import dem_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      force_ccm,
    input  logic      strobe,
    input  logic      entry_hit,
    input  logic      neg_seen,
    output dem_mode_e mode
);
    logic exit_armed;

    // Mode and exit flag update; the mode pin overrides everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MODE_CCM;
            exit_armed <= 1'b0;
        end else if (force_ccm) begin
            mode       <= MODE_CCM;
            exit_armed <= 1'b0;
        end else if (mode == MODE_CCM) begin
            exit_armed <= 1'b0;
            if (entry_hit) begin
                mode <= MODE_DEM;
            end
        end else begin
            if (strobe && exit_armed) begin
                mode       <= MODE_CCM;
                exit_armed <= 1'b0;
            end else if (neg_seen) begin
                exit_armed <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dem_lg_gate.sv
// Derives the low-side permit and the window code from the mode.
// Assumes: pos_seen marks a cycle with the low-side gate on and a
// positive phase reading (reverse inductor current).
module dem_lg_gate
    import dem_pkg::*;
#(
    parameter int WIN_W    = 8,
    parameter int WIN_BASE = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dem_mode_e        mode,
    input  logic             strobe,
    input  logic             pos_seen,
    output logic             lg_permit,
    output logic [WIN_W-1:0] win_sel
);
    localparam logic [WIN_W-1:0] WIN_NORM = WIN_W'(WIN_BASE);
    localparam logic [WIN_W-1:0] WIN_WIDE = WIN_W'(win_enlarged(WIN_BASE));

    logic blocked;

    // Reverse-current block: set on detection, released at a new PWM cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked <= 1'b0;
        end else if (mode != MODE_DEM) begin
            blocked <= 1'b0;
        end else if (pos_seen) begin
            blocked <= 1'b1;
        end else if (strobe) begin
            blocked <= 1'b0;
        end
    end

    // Permit is unconditional in continuous conduction.
    always_comb begin
        lg_permit = (mode == MODE_CCM) || !blocked;
    end

    // Window code selected by mode.
    always_comb begin
        win_sel = (mode == MODE_DEM) ? WIN_WIDE : WIN_NORM;
    end
endmodule

// File: rtl/dem_ctrl_top.sv
// Conduction mode selector top: run counter, mode state, permit/window.
// Assumes all inputs are synchronous to clk.
module dem_ctrl_top
    import dem_pkg::*;
#(
    parameter int ENTRY_COUNT = 8,
    parameter int WIN_W       = 8,
    parameter int WIN_BASE    = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_ccm,
    input  logic             pwm_strobe,
    input  logic             lg_on,
    input  logic             phase_pos,
    output logic             dem_mode,
    output logic             lg_permit,
    output logic [WIN_W-1:0] win_sel
);
    dem_mode_e mode;
    logic      entry_hit;
    logic      pos_seen;
    logic      neg_seen;
    logic      cnt_clear;

    // Phase polarity qualified by the low-side gate.
    always_comb begin
        pos_seen  = lg_on && phase_pos;
        neg_seen  = lg_on && !phase_pos;
        cnt_clear = force_ccm || (mode == MODE_DEM);
    end

    dem_entry_counter #(
        .ENTRY_COUNT (ENTRY_COUNT)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .strobe  (pwm_strobe),
        .qualify (pos_seen),
        .hit     (entry_hit)
    );

    dem_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_ccm (force_ccm),
        .strobe    (pwm_strobe),
        .entry_hit (entry_hit),
        .neg_seen  (neg_seen),
        .mode      (mode)
    );

    dem_lg_gate #(
        .WIN_W    (WIN_W),
        .WIN_BASE (WIN_BASE)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .strobe    (pwm_strobe),
        .pos_seen  (pos_seen),
        .lg_permit (lg_permit),
        .win_sel   (win_sel)
    );

    assign dem_mode = (mode == MODE_DEM);
endmodule

// File: rtl/dem_ctrl_checker.sv
// Port-level properties of the conduction mode selector, bound to the top.
module dem_ctrl_checker #(
    parameter int WIN_W    = 8,
    parameter int WIN_BASE = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             force_ccm,
    input logic             pwm_strobe,
    input logic             lg_on,
    input logic             phase_pos,
    input logic             dem_mode,
    input logic             lg_permit,
    input logic [WIN_W-1:0] win_sel
);
    localparam logic [WIN_W-1:0] NORM = WIN_W'(WIN_BASE);
    localparam logic [WIN_W-1:0] WIDE = WIN_W'(WIN_BASE + WIN_BASE / 3);

    AST_FORCE_HOLDS_CCM: assert property (@(posedge clk) disable iff (!rst_n)
        force_ccm |=> !dem_mode); // R1

    AST_ENTRY_ON_QUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dem_mode) |-> ($past(pwm_strobe) && $past(lg_on) && $past(phase_pos) && !$past(force_ccm))); // R2

    AST_EXIT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dem_mode) |-> ($past(pwm_strobe) || $past(force_ccm))); // R3

    AST_WINDOW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel == (dem_mode ? WIDE : NORM))); // R4

    AST_PERMIT_IN_CCM: assert property (@(posedge clk) disable iff (!rst_n)
        !dem_mode |-> lg_permit); // R5

    AST_PERMIT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dem_mode && $past(dem_mode) && $past(lg_on) && $past(phase_pos)) |-> !lg_permit); // R5
endmodule

bind dem_ctrl_top dem_ctrl_checker #(
    .WIN_W    (WIN_W),
    .WIN_BASE (WIN_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_ccm  (force_ccm),
    .pwm_strobe (pwm_strobe),
    .lg_on      (lg_on),
    .phase_pos  (phase_pos),
    .dem_mode   (dem_mode),
    .lg_permit  (lg_permit),
    .win_sel    (win_sel)
);

// File: tb/dem_ctrl_top_tb_top.sv
// Self-checking sweep bench for the conduction mode selector.
module dem_ctrl_top_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int ENTRY_COUNT = 8;
    localparam int WIN_W       = 8;
    localparam int WIN_BASE    = 48;
    localparam int WIN_WIDE    = WIN_BASE * 4 / 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             force_ccm = 1'b0;
    logic             pwm_strobe = 1'b0;
    logic             lg_on = 1'b0;
    logic             phase_pos = 1'b0;
    logic             dem_mode;
    logic             lg_permit;
    logic [WIN_W-1:0] win_sel;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dem_ctrl_top #(
        .ENTRY_COUNT (ENTRY_COUNT),
        .WIN_W       (WIN_W),
        .WIN_BASE    (WIN_BASE)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_ccm  (force_ccm),
        .pwm_strobe (pwm_strobe),
        .lg_on      (lg_on),
        .phase_pos  (phase_pos),
        .dem_mode   (dem_mode),
        .lg_permit  (lg_permit),
        .win_sel    (win_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_mode(input string req, input bit exp_dem);
        check({req, " mode"}, int'(dem_mode), int'(exp_dem));
        check({req, " window"}, int'(win_sel), exp_dem ? WIN_WIDE : WIN_BASE);
    endtask

    // One PWM strobe with given gate/phase; returns at the next falling edge.
    task automatic strobe(input bit lg, input bit ph);
        @(negedge clk);
        pwm_strobe = 1'b1;
        lg_on      = lg;
        phase_pos  = ph;
        @(negedge clk);
        pwm_strobe = 1'b0;
        lg_on      = 1'b0;
        phase_pos  = 1'b0;
    endtask

    // One non-strobe cycle with given gate/phase.
    task automatic mid_cycle(input bit lg, input bit ph);
        @(negedge clk);
        lg_on     = lg;
        phase_pos = ph;
        @(negedge clk);
        lg_on     = 1'b0;
        phase_pos = 1'b0;
    endtask

    task automatic force_pulse();
        @(negedge clk);
        force_ccm = 1'b1;
        @(negedge clk);
        force_ccm = 1'b0;
    endtask

    task automatic run_qual(input int n);
        for (int i = 0; i < n; i++) strobe(1'b1, 1'b1);
    endtask

    task automatic enter_dem();
        force_pulse();
        run_qual(ENTRY_COUNT);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check_mode("R8", 1'b0);
        check("R8 permit", int'(lg_permit), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_mode("R8 after release", 1'b0);

        // R2/R4: sweep run length
        for (int k = 0; k <= ENTRY_COUNT + 2; k++) begin
            force_pulse();
            for (int i = 0; i < k; i++) begin
                strobe(1'b1, 1'b1);
                check_mode("R2 run", (i + 1) >= ENTRY_COUNT);
            end
        end

        // R6: broken runs at every position, both break kinds
        for (int j = 1; j < ENTRY_COUNT; j++) begin
            for (int kind = 0; kind < 2; kind++) begin
                force_pulse();
                run_qual(j);
                if (kind == 0) strobe(1'b0, 1'b1);
                else           strobe(1'b1, 1'b0);
                check_mode("R6 break", 1'b0);
                run_qual(ENTRY_COUNT - 1);
                check_mode("R6 short", 1'b0);
                strobe(1'b1, 1'b1);
                check_mode("R6 full", 1'b1);
            end
        end

        // R1: pin held high
        @(negedge clk);
        force_ccm = 1'b1;
        for (int i = 0; i < ENTRY_COUNT + 4; i++) begin
            strobe(1'b1, 1'b1);
            check_mode("R1 held", 1'b0);
            check("R1 permit", int'(lg_permit), 1);
        end
        @(negedge clk);
        force_ccm = 1'b0;

        // R3: arming on a strobe cycle
        enter_dem();
        check_mode("R3 entered", 1'b1);
        strobe(1'b1, 1'b0);
        check_mode("R3 armed", 1'b1);
        strobe(1'b0, 1'b0);
        check_mode("R3 exit", 1'b0);
        run_qual(ENTRY_COUNT - 1);
        check_mode("R3 count restart", 1'b0);
        strobe(1'b1, 1'b1);
        check_mode("R3 reentry", 1'b1);

        // R3: arming between strobes
        mid_cycle(1'b1, 1'b0);
        check_mode("R3 mid armed", 1'b1);
        mid_cycle(1'b0, 1'b0);
        check_mode("R3 mid wait", 1'b1);
        strobe(1'b0, 1'b0);
        check_mode("R3 mid exit", 1'b0);

        // R3: negative phase with gate off does not arm
        enter_dem();
        mid_cycle(1'b0, 1'b0);
        strobe(1'b0, 1'b0);
        check_mode("R3 gate off", 1'b1);

        // R5: permit blocking in diode emulation
        check("R5 permit start", int'(lg_permit), 1);
        mid_cycle(1'b1, 1'b1);
        check("R5 blocked", int'(lg_permit), 0);
        mid_cycle(1'b0, 1'b0);
        check("R5 stays blocked", int'(lg_permit), 0);
        strobe(1'b0, 1'b0);
        check("R5 released", int'(lg_permit), 1);
        strobe(1'b1, 1'b1);
        check("R5 blocked on strobe", int'(lg_permit), 0);
        check_mode("R5 still dem", 1'b1);

        // R7: pin pulse inside diode emulation
        mid_cycle(1'b1, 1'b0);
        force_pulse();
        check_mode("R7 forced", 1'b0);
        check("R7 permit", int'(lg_permit), 1);
        run_qual(ENTRY_COUNT - 1);
        check_mode("R7 cleared", 1'b0);
        strobe(1'b1, 1'b1);
        check_mode("R7 reentry", 1'b1);
        strobe(1'b0, 1'b0);
        check_mode("R7 armed cleared", 1'b1);

        // R5: reverse-current pattern in continuous conduction keeps permit
        force_pulse();
        mid_cycle(1'b1, 1'b1);
        check("R5 ccm permit", int'(lg_permit), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule